// File: doc/BRIEF.md
# Coprocessor Control Register Transfer Unit

This block sits between a host processor and a vector coprocessor. It carries out single-register moves in both directions: the host reads a 32-bit control or integer register of the coprocessor, or writes one. Every read comes back to the host as a 64-bit value, sign-extended from bit 31. The host presents a register index, a direction, a write value and an interlock flag. When the interlock flag is set, the block holds the host with a stall signal until the coprocessor's microprogram either stops running or raises its break flag.

Writes pass through a filter that depends on the register index:

- Slot 0 stays zero.
- The three read-only slots ignore writes.
- The control slot keeps only the bits that a fixed mask selects. Its break and reset bits also produce single-cycle pulses to the two processing units.
- A write to the start slot launches the second unit's microprogram, but only when that unit is idle.
- Every other slot stores the full word.

Top module: `ccr_xfer_unit`

## Requirements
- R1: After synchronous reset all 32 register slots hold zero. `stall_o`, `rd_valid_o`, every pulse output and `u1_start_o` are low.
- R2: An accepted write (`req_dir_i`=1) to an ordinary slot stores all 32 bits. An accepted read (`req_dir_i`=0) raises `rd_valid_o` for exactly one cycle, in the cycle after acceptance, with the slot's value. The ordinary slots are every slot except 0, 17, 26, 27, 28 and 29.
- R3: On a read, `rd_data_o[63:32]` is all ones when bit 31 of the value read is set and all zeros otherwise. `rd_data_o[31:0]` is the value itself.
- R4: A write to slot 0 has no effect. A read of slot 0 returns zero.
- R5: Writes to the read-only slots 17 (MAC flags), 26 (program counter) and 29 (status) are ignored. A read of slot 29 returns the live status: bit 0 is `cop_running_i`, bit 8 is `u1_busy_i`, and all other bits are zero.
- R6: A write to the control slot 28 stores only the value ANDed with 0x0000_0C0C.
- R7: A write to slot 28 pulses outputs for one cycle, in the cycle after acceptance, and only for bits that are set in the written value:
  - bit 0 pulses `u0_break_o`
  - bit 1 pulses `u0_reset_o`
  - bit 8 pulses `u1_break_o`
  - bit 9 pulses `u1_reset_o`
- R8: A write to the start slot 27 pulses `u1_start_o` for one cycle, in the cycle after acceptance, with `u1_start_addr_o` set to the low 16 bits of the value. This happens only if `u1_busy_i` is low in the acceptance cycle. The slot stores nothing and reads as zero.
- R9: While `req_valid_i`, `req_wait_i` and `cop_running_i` are high and `cop_break_i` is low, `stall_o` is high and no access takes place. The access completes in the first cycle in which this stall condition is false.
- R10: With `req_wait_i` low, a request is accepted in its first cycle whatever the coprocessor state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Transfer request; held by host while stalled |
| req_dir_i | input | 1 | 1 = write to coprocessor, 0 = read |
| req_wait_i | input | 1 | Interlock flag |
| req_idx_i | input | 5 | Register slot index |
| req_wdata_i | input | 32 | Write value |
| cop_running_i | input | 1 | Coprocessor microprogram running |
| cop_break_i | input | 1 | Coprocessor break flag raised |
| u1_busy_i | input | 1 | Second unit busy |
| stall_o | output | 1 | Host stall |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Sign-extended read result |
| u0_break_o | output | 1 | Unit 0 force-break pulse |
| u0_reset_o | output | 1 | Unit 0 reset pulse |
| u1_break_o | output | 1 | Unit 1 force-break pulse |
| u1_reset_o | output | 1 | Unit 1 reset pulse |
| u1_start_o | output | 1 | Unit 1 launch pulse |
| u1_start_addr_o | output | 16 | Unit 1 launch address |

## Verification
Two functions can fall in the same cycle: the release of an interlock stall and the completion of the held register access. The bench provokes this by keeping the coprocessor running under an interlocked read and an interlocked write. It first confirms that no result appears while the stall holds. It then lowers the running flag, or raises the break flag, and expects the result in the cycle right after release. For the write, a readback of the stored value judges the outcome. A second coincidence is a single control write that sets all four break and reset bits at once. Here the bench expects all four pulses in the same cycle, together with the masked stored value.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    // slot indices whose behaviour differs from plain storage
    localparam int SLOT_MACF   = 17;
    localparam int SLOT_PC     = 26;
    localparam int SLOT_START  = 27;
    localparam int SLOT_CTRL   = 28;
    localparam int SLOT_STATUS = 29;

    localparam logic [31:0] CTRL_KEEP_MASK = 32'h0000_0C0C;

    // control-slot pulse bit positions
    localparam int CB_U0_BREAK = 0;
    localparam int CB_U0_RESET = 1;
    localparam int CB_U1_BREAK = 8;
    localparam int CB_U1_RESET = 9;

    // status-slot live bit positions
    localparam int SB_RUNNING = 0;
    localparam int SB_U1_BUSY = 8;

    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } xfer_dir_e;

    typedef struct packed {
        logic u1_reset;
        logic u1_break;
        logic u0_reset;
        logic u0_break;
    } ctl_pulse_t;

    function automatic logic is_read_only(input int idx);
        return (idx == SLOT_MACF) || (idx == SLOT_PC) || (idx == SLOT_STATUS);
    endfunction

endpackage

// File: rtl/ccr_interlock.sv
module ccr_interlock (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_wait,
    input  logic cop_running,
    input  logic cop_break,
    output logic stall,
    output logic fire
);
    logic hold;

    assign hold  = req_valid && req_wait && cop_running && !cop_break;
    assign stall = hold;
    assign fire  = req_valid && !hold;

    // R9: a request never fires in a cycle where it is stalled
    a_r9_no_fire_when_stalled: assert property (@(posedge clk) disable iff (rst)
        stall |-> !fire);

    // R10: an un-interlocked request is never stalled
    a_r10_no_wait_no_stall: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_wait) |-> fire);
endmodule

// File: rtl/ccr_wfilter.sv
module ccr_wfilter
    import ccr_pkg::*;
#(
    parameter int DW = 32,
    parameter int NREGS = 32,
    localparam int IW = $clog2(NREGS)
) (
    input  logic          fire,
    input  xfer_dir_e     dir,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    input  logic          u1_busy,
    output logic          we,
    output logic [DW-1:0] we_data,
    output ctl_pulse_t    pulses,
    output logic          start
);
    int   slot;
    logic wr;

    always_comb begin
        slot    = int'(idx);
        wr      = fire && (dir == DIR_WRITE);
        we      = wr && (slot != 0) && !is_read_only(slot) && (slot != SLOT_START);
        we_data = (slot == SLOT_CTRL) ? (wdata & DW'(CTRL_KEEP_MASK)) : wdata;
        pulses  = '0;
        if (wr && slot == SLOT_CTRL) begin
            pulses.u0_break = wdata[CB_U0_BREAK];
            pulses.u0_reset = wdata[CB_U0_RESET];
            pulses.u1_break = wdata[CB_U1_BREAK];
            pulses.u1_reset = wdata[CB_U1_RESET];
        end
        start = wr && (slot == SLOT_START) && !u1_busy;
    end
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile #(
    parameter int DW = 32,
    parameter int NREGS = 32,
    localparam int IW = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] slots [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[g] <= '0;
            else if (we && waddr == IW'(g))
                slots[g] <= wdata;
        end
    end

    assign rdata = slots[raddr];

    // R4: slot 0 never leaves zero
    a_r4_slot0_zero: assert property (@(posedge clk) disable iff (rst)
        slots[0] == '0);

    // R5: read-only slots keep their reset contents
    a_r5_ro_unchanged: assert property (@(posedge clk) disable iff (rst)
        (slots[17] == '0) && (slots[26] == '0) && (slots[29] == '0));
endmodule

// File: rtl/ccr_xfer_unit.sv
module ccr_xfer_unit
    import ccr_pkg::*;
#(
    parameter int DW = 32,
    parameter int NREGS = 32,
    parameter int AW = 16,
    localparam int IW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid_i,
    input  logic            req_dir_i,
    input  logic            req_wait_i,
    input  logic [IW-1:0]   req_idx_i,
    input  logic [DW-1:0]   req_wdata_i,
    input  logic            cop_running_i,
    input  logic            cop_break_i,
    input  logic            u1_busy_i,
    output logic            stall_o,
    output logic            rd_valid_o,
    output logic [2*DW-1:0] rd_data_o,
    output logic            u0_break_o,
    output logic            u0_reset_o,
    output logic            u1_break_o,
    output logic            u1_reset_o,
    output logic            u1_start_o,
    output logic [AW-1:0]   u1_start_addr_o
);
    xfer_dir_e     dir;
    logic          fire;
    logic          we;
    logic [DW-1:0] we_data;
    ctl_pulse_t    pulses, pulses_q;
    logic          start;
    logic [DW-1:0] rf_rdata;
    logic [DW-1:0] rsel;
    int            slot;

    assign dir = xfer_dir_e'(req_dir_i);

    ccr_interlock u_lock (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid_i),
        .req_wait    (req_wait_i),
        .cop_running (cop_running_i),
        .cop_break   (cop_break_i),
        .stall       (stall_o),
        .fire        (fire)
    );

    ccr_wfilter #(.DW(DW), .NREGS(NREGS)) u_filt (
        .fire    (fire),
        .dir     (dir),
        .idx     (req_idx_i),
        .wdata   (req_wdata_i),
        .u1_busy (u1_busy_i),
        .we      (we),
        .we_data (we_data),
        .pulses  (pulses),
        .start   (start)
    );

    ccr_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (req_idx_i),
        .wdata (we_data),
        .raddr (req_idx_i),
        .rdata (rf_rdata)
    );

    always_comb begin
        slot = int'(req_idx_i);
        rsel = rf_rdata;
        if (slot == SLOT_STATUS) begin
            rsel = '0;
            rsel[SB_RUNNING] = cop_running_i;
            rsel[SB_U1_BUSY] = u1_busy_i;
        end else if (slot == 0 || slot == SLOT_START) begin
            rsel = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o      <= 1'b0;
            rd_data_o       <= '0;
            pulses_q        <= '0;
            u1_start_o      <= 1'b0;
            u1_start_addr_o <= '0;
        end else begin
            rd_valid_o <= fire && (dir == DIR_READ);
            if (fire && dir == DIR_READ)
                rd_data_o <= {{DW{rsel[DW-1]}}, rsel};
            pulses_q   <= pulses;
            u1_start_o <= start;
            if (start)
                u1_start_addr_o <= req_wdata_i[AW-1:0];
        end
    end

    assign u0_break_o = pulses_q.u0_break;
    assign u0_reset_o = pulses_q.u0_reset;
    assign u1_break_o = pulses_q.u1_break;
    assign u1_reset_o = pulses_q.u1_reset;

    // R3: read result upper half mirrors bit 31
    a_r3_sign_ext: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |-> (rd_data_o[2*DW-1:DW] == {DW{rd_data_o[DW-1]}}));

    // R9: a stalled cycle yields no read result next cycle
    a_r9_stall_blocks_read: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !rd_valid_o);

    // R7: a unit-0 reset pulse follows a write to the control slot with bit 1 set
    a_r7_reset_cause: assert property (@(posedge clk) disable iff (rst)
        u0_reset_o |-> $past(fire && req_dir_i && int'(req_idx_i) == SLOT_CTRL
                             && req_wdata_i[CB_U0_RESET]));

    // R8: launch only when the second unit was idle
    a_r8_start_idle: assert property (@(posedge clk) disable iff (rst)
        u1_start_o |-> $past(!u1_busy_i && fire));
endmodule

// File: tb/ccr_xfer_unit_tb_top.sv
module ccr_xfer_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic        req_dir_i = 1'b0;
    logic        req_wait_i = 1'b0;
    logic [4:0]  req_idx_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic        cop_running_i = 1'b0;
    logic        cop_break_i = 1'b0;
    logic        u1_busy_i = 1'b0;
    logic        stall_o, rd_valid_o;
    logic [63:0] rd_data_o;
    logic        u0_break_o, u0_reset_o, u1_break_o, u1_reset_o, u1_start_o;
    logic [15:0] u1_start_addr_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ccr_xfer_unit dut_i (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid_i), .req_dir_i(req_dir_i), .req_wait_i(req_wait_i),
        .req_idx_i(req_idx_i), .req_wdata_i(req_wdata_i),
        .cop_running_i(cop_running_i), .cop_break_i(cop_break_i), .u1_busy_i(u1_busy_i),
        .stall_o(stall_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .u0_break_o(u0_break_o), .u0_reset_o(u0_reset_o),
        .u1_break_o(u1_break_o), .u1_reset_o(u1_reset_o),
        .u1_start_o(u1_start_o), .u1_start_addr_o(u1_start_addr_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one un-interlocked write, inputs driven at negedge
    task automatic do_write(input int idx, input logic [31:0] val);
        req_valid_i = 1'b1; req_dir_i = 1'b1; req_wait_i = 1'b0;
        req_idx_i = 5'(idx); req_wdata_i = val;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic do_read(input int idx, input string req, input logic [63:0] exp);
        req_valid_i = 1'b1; req_dir_i = 1'b0; req_wait_i = 1'b0;
        req_idx_i = 5'(idx);
        @(negedge clk);
        req_valid_i = 1'b0;
        check({req, " rd_valid"}, 64'(rd_valid_o), 64'd1);
        check({req, " data"}, rd_data_o, exp);
        @(negedge clk);
        check({req, " rd_valid one cycle"}, 64'(rd_valid_o), 64'd0);
    endtask

    task automatic t_reset;
        check("R1 stall", 64'(stall_o), 0);
        check("R1 rd_valid", 64'(rd_valid_o), 0);
        check("R1 pulses", 64'({u0_break_o, u0_reset_o, u1_break_o, u1_reset_o, u1_start_o}), 0);
        do_read(5, "R1 slot5 zero", 64'd0);
        do_read(31, "R1 slot31 zero", 64'd0);
    endtask

    task automatic t_plain;
        do_write(5, 32'h1234_5678);
        do_read(5, "R2 slot5", 64'h0000_0000_1234_5678);
        do_write(31, 32'hCAFE_0001);
        do_read(31, "R3 neg ext", 64'hFFFF_FFFF_CAFE_0001);
        do_write(6, 32'h7FFF_FFFF);
        do_read(6, "R3 pos ext", 64'h0000_0000_7FFF_FFFF);
    endtask

    task automatic t_zero_ro;
        do_write(0, 32'hDEAD_BEEF);
        do_read(0, "R4 slot0", 64'd0);
        do_write(17, 32'hFFFF_FFFF);
        do_read(17, "R5 mac ignored", 64'd0);
        do_write(26, 32'h0000_0100);
        do_read(26, "R5 pc ignored", 64'd0);
        do_write(29, 32'hFFFF_FFFF);
        do_read(29, "R5 status ignored", 64'd0);
        cop_running_i = 1'b1; u1_busy_i = 1'b1;
        do_read(29, "R5 status live", 64'h0000_0000_0000_0101);
        cop_running_i = 1'b0; u1_busy_i = 1'b0;
    endtask

    task automatic t_ctrl;
        do_write(28, 32'h0000_0002);
        check("R7 u0_reset only", 64'({u0_break_o, u0_reset_o, u1_break_o, u1_reset_o}), 64'b0100);
        @(negedge clk);
        check("R7 single cycle", 64'({u0_break_o, u0_reset_o, u1_break_o, u1_reset_o}), 0);
        do_read(28, "R6 masked 0002", 64'd0);
        do_write(28, 32'hFFFF_FFFF);
        check("R7 all four", 64'({u0_break_o, u0_reset_o, u1_break_o, u1_reset_o}), 64'b1111);
        do_read(28, "R6 masked all", 64'h0000_0000_0000_0C0C);
        do_write(28, 32'h0000_0100);
        check("R7 u1_break only", 64'({u0_break_o, u0_reset_o, u1_break_o, u1_reset_o}), 64'b0010);
        @(negedge clk);
    endtask

    task automatic t_start;
        u1_busy_i = 1'b1;
        do_write(27, 32'h0000_4444);
        check("R8 busy no start", 64'(u1_start_o), 0);
        u1_busy_i = 1'b0;
        do_write(27, 32'hABCD_1234);
        check("R8 start", 64'(u1_start_o), 1);
        check("R8 addr", 64'(u1_start_addr_o), 64'h1234);
        @(negedge clk);
        check("R8 start one cycle", 64'(u1_start_o), 0);
        do_read(27, "R8 not stored", 64'd0);
    endtask

    task automatic t_interlock;
        // interlocked read held by running, released by running dropping
        cop_running_i = 1'b1;
        req_valid_i = 1'b1; req_dir_i = 1'b0; req_wait_i = 1'b1; req_idx_i = 5'd5;
        #1 check("R9 stall asserted", 64'(stall_o), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R9 no result while stalled", 64'(rd_valid_o), 0);
            check("R9 stall held", 64'(stall_o), 1);
        end
        cop_running_i = 1'b0;
        #1 check("R9 stall released", 64'(stall_o), 0);
        @(negedge clk);
        req_valid_i = 1'b0;
        check("R9 read completes", 64'(rd_valid_o), 1);
        check("R9 read data", rd_data_o, 64'h0000_0000_1234_5678);
        // interlocked write released by break flag
        cop_running_i = 1'b1;
        req_valid_i = 1'b1; req_dir_i = 1'b1; req_wait_i = 1'b1;
        req_idx_i = 5'd7; req_wdata_i = 32'h8000_0007;
        repeat (2) @(negedge clk);
        check("R9 write stalled", 64'(stall_o), 1);
        cop_break_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0; cop_break_i = 1'b0;
        cop_running_i = 1'b0;
        do_read(7, "R9 write landed", 64'hFFFF_FFFF_8000_0007);
        // no wait bit: no stall even while running
        cop_running_i = 1'b1;
        req_valid_i = 1'b1; req_dir_i = 1'b0; req_wait_i = 1'b0; req_idx_i = 5'd6;
        #1 check("R10 no stall", 64'(stall_o), 0);
        @(negedge clk);
        req_valid_i = 1'b0;
        check("R10 completes", 64'(rd_valid_o), 1);
        check("R10 data", rd_data_o, 64'h0000_0000_7FFF_FFFF);
        cop_running_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_plain();
        t_zero_ro();
        t_ctrl();
        t_start();
        t_interlock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule